// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a non-pipelined 32-bit RISC core. It reads the instruction register, a busy flag from main memory and a comparison flag from the ALU. In every cycle it drives the datapath's latch enables, the ALU operation and operand selects, the memory read and write strobes, and the register-file write enable with its destination choice. The datapath itself (registers, ALU, shifter, register file, memory) sits outside the block.

Each instruction starts with a fetch, then a single decode cycle that also advances the program counter and latches both source operands. Execution then follows a path chosen by the instruction class, and arithmetic, test, shift and load instructions end in a write-back cycle. Instruction lengths therefore vary, from a three-cycle undefined opcode to a load that waits on memory twice. The block has no valid/ready stream edge. Memory uses a plain request/busy exchange instead. A strobe is raised for one cycle, and only while busy is low. The memory then holds busy high for as many cycles as it needs. The sequencer stays in the memory state until the first later cycle in which busy reads low.

Top module: `mc_sequencer`

## Requirements
- R1: While reset is held and in the cycles after it, no write, PC, IR, C, MAR or MDR enable is raised until a fetch has completed. Reset leaves the machine in fetch with no request outstanding.
- R2: In fetch, a one-cycle read strobe `mem_rd` is raised in the first cycle with `mem_busy` low. The state is held until a later cycle with `mem_busy` low, and `ir_ce` is raised in that cycle. With busy held for L cycles after the strobe, fetch lasts 2+L cycles.
- R3: No strobe is raised while `mem_busy` is high. There is at most one strobe per memory state, and `mem_rd` and `mem_wr` are never raised together.
- R4: The cycle after `ir_ce` is decode, which lasts one cycle. It raises `pc_ce`, `a_ce` and `b_ce` with `alu_a_sel`=1 (PC), `alu_b_sel`=3 (constant one) and `alu_op`=0 (add).
- R5: Bits [31:26]=000000 mark the register form, whose operation comes from bits [5:0]. In that form, function 100011 is add, 100010 is subtract, 100100 is and, 000000 is shift left by one and 000010 is shift right by one. The immediate-form opcodes are 001011 add-immediate, 011010 set-if-equal-immediate, 100011 load, 101011 store, 000100 branch-if-zero, 000101 branch-if-nonzero, 010110 jump-register and 010111 jump-and-link-register. Any other code returns to fetch right after decode with no write.
- R6: ALU instructions take one execute cycle with `c_ce`, `c_src`=0 (ALU) and `alu_op` set to add=0, sub=1, and=2 or equal-test=3. In that cycle `alu_b_sel` is 1 (immediate) for the immediate form and 0 (B) for the register form. A write-back cycle follows with `gpr_we`, and `gpr_dst` is 0 (bits [20:16]) for the immediate form or 1 (bits [15:11]) for the register form.
- R7: A shift takes one execute cycle with `c_ce`, `c_src`=1 and `shift_right` from the function code, then a write-back with `gpr_dst`=1.
- R8: A load passes four states. First comes `mar_ce` with A plus immediate. Next a read strobe waits on busy and raises `mdr_ce` with `mdr_sel`=0 (memory) at completion. Then `c_ce` with `c_src`=2, and finally write-back with `gpr_dst`=0.
- R9: A store passes three states: `mar_ce`, then `mdr_ce` with `mdr_sel`=1 (B), then a write strobe `mem_wr` that waits on busy. It makes no register write.
- R10: A branch spends one check cycle with `alu_op`=3 and `alu_b_sel`=2 (zero). It is taken when `cmp_true` is 1 for branch-if-zero or 0 for branch-if-nonzero. A taken branch adds a cycle with `pc_ce`, `alu_a_sel`=1 and `alu_b_sel`=1. An untaken branch goes straight to fetch.
- R11: Jump-register spends one cycle with `pc_ce`, `alu_a_sel`=0, `alu_b_sel`=2 and add.
- R12: Jump-and-link-register runs three cycles. The first has `c_ce` with `c_src`=3 (PC). The second has `gpr_we` with `gpr_dst`=2 (link register). The third is the same as the jump-register cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 32 | Instruction register contents |
| mem_busy | input | 1 | Memory busy flag |
| cmp_true | input | 1 | ALU comparison result |
| ir_ce | output | 1 | Instruction register load enable |
| pc_ce | output | 1 | Program counter load enable |
| a_ce | output | 1 | Operand A latch enable |
| b_ce | output | 1 | Operand B latch enable |
| c_ce | output | 1 | Result C latch enable |
| mar_ce | output | 1 | Memory address register load enable |
| mdr_ce | output | 1 | Memory data register load enable |
| mdr_sel | output | 1 | MDR source: 0 memory, 1 operand B |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_wr | output | 1 | One-cycle memory write strobe |
| alu_op | output | 2 | 0 add, 1 sub, 2 and, 3 equal-test |
| alu_a_sel | output | 1 | ALU first operand: 0 A, 1 PC |
| alu_b_sel | output | 2 | ALU second operand: 0 B, 1 immediate, 2 zero, 3 one |
| shift_right | output | 1 | Shifter direction |
| c_src | output | 2 | C source: 0 ALU, 1 shifter, 2 MDR, 3 PC |
| gpr_we | output | 1 | Register file write enable |
| gpr_dst | output | 2 | Destination: 0 bits [20:16], 1 bits [15:11], 2 link register |

## Verification
The bench builds the block with its default widths: a 32-bit instruction with 6-bit opcode and function fields. At that size, every one of the 64 opcodes and every one of the 64 register-form function codes can be run. Each branch is run with both comparison outcomes, so all ten classes and every undefined code get their cycle count, write pattern and select values checked. The sweep is repeated with memory busy latencies of 0, 1 and 2 cycles, so the fetch, load and store waits are measured against the 2+L formula.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  typedef enum logic [4:0] {
    S_FETCH, S_DECODE, S_EXE_ALU, S_EXE_SHIFT, S_ADDR,
    S_LD_MEM, S_LD_COPY, S_ST_COPY, S_ST_MEM,
    S_BR_CHK, S_BR_TAKEN, S_JR, S_JL_SAVE, S_JL_WB, S_JL_JUMP,
    S_WB_I, S_WB_R
  } state_t;

  typedef enum logic [3:0] {
    C_ALU_R, C_ALU_I, C_SHIFT, C_LOAD, C_STORE,
    C_BEQZ, C_BNEZ, C_JR, C_JALR, C_BAD
  } iclass_t;

  localparam logic [1:0] OP_ADD = 2'd0, OP_SUB = 2'd1, OP_AND = 2'd2, OP_TEQ = 2'd3;
  localparam logic [1:0] BS_B = 2'd0, BS_IMM = 2'd1, BS_ZERO = 2'd2, BS_ONE = 2'd3;
  localparam logic [1:0] CS_ALU = 2'd0, CS_SHIFT = 2'd1, CS_MDR = 2'd2, CS_PC = 2'd3;
  localparam logic [1:0] DS_I = 2'd0, DS_R = 2'd1, DS_LINK = 2'd2;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ADDI  = 6'b001011;
  localparam logic [5:0] OPC_SEQI  = 6'b011010;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQZ  = 6'b000100;
  localparam logic [5:0] OPC_BNEZ  = 6'b000101;
  localparam logic [5:0] OPC_JR    = 6'b010110;
  localparam logic [5:0] OPC_JALR  = 6'b010111;

  localparam logic [5:0] FN_ADD = 6'b100011;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_SHL = 6'b000000;
  localparam logic [5:0] FN_SHR = 6'b000010;

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
#(
  parameter int IR_W = 32,
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic [IR_W-1:0] ir,
  output iclass_t         cls,
  output logic [1:0]      alu_op,
  output logic            shift_right
);
  logic [OP_W-1:0] opc;
  logic [FN_W-1:0] fn;
  logic            dec_unused;

  assign opc = ir[IR_W-1 -: OP_W];
  assign fn  = ir[FN_W-1:0];
  // register and immediate fields belong to the datapath
  assign dec_unused = ^ir[IR_W-OP_W-1:FN_W];

  // R5: class and operation from opcode / function code
  always_comb begin
    cls         = C_BAD;
    alu_op      = OP_ADD;
    shift_right = 1'b0;
    if (opc == OP_W'(OPC_RTYPE)) begin
      if (fn == FN_W'(FN_ADD))      begin cls = C_ALU_R; alu_op = OP_ADD; end
      else if (fn == FN_W'(FN_SUB)) begin cls = C_ALU_R; alu_op = OP_SUB; end
      else if (fn == FN_W'(FN_AND)) begin cls = C_ALU_R; alu_op = OP_AND; end
      else if (fn == FN_W'(FN_SHL)) begin cls = C_SHIFT; shift_right = 1'b0; end
      else if (fn == FN_W'(FN_SHR)) begin cls = C_SHIFT; shift_right = 1'b1; end
    end
    else if (opc == OP_W'(OPC_ADDI))  begin cls = C_ALU_I; alu_op = OP_ADD; end
    else if (opc == OP_W'(OPC_SEQI))  begin cls = C_ALU_I; alu_op = OP_TEQ; end
    else if (opc == OP_W'(OPC_LOAD))  cls = C_LOAD;
    else if (opc == OP_W'(OPC_STORE)) cls = C_STORE;
    else if (opc == OP_W'(OPC_BEQZ))  cls = C_BEQZ;
    else if (opc == OP_W'(OPC_BNEZ))  cls = C_BNEZ;
    else if (opc == OP_W'(OPC_JR))    cls = C_JR;
    else if (opc == OP_W'(OPC_JALR))  cls = C_JALR;
  end
endmodule

// File: rtl/ctl_memwait.sv
module ctl_memwait (
  input  logic clk,
  input  logic rst_n,
  input  logic in_mem,
  input  logic busy,
  output logic strobe,
  output logic done
);
  logic issued_q;

  assign strobe = in_mem & ~issued_q & ~busy;
  assign done   = in_mem &  issued_q & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      issued_q <= 1'b0;
    else if (strobe) issued_q <= 1'b1;
    else if (done)   issued_q <= 1'b0;
  end

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R2
  hold_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> in_mem);

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_mem |-> !issued_q);
endmodule

// File: rtl/ctl_outputs.sv
module ctl_outputs
  import ctl_pkg::*;
(
  input  state_t     state,
  input  iclass_t    cls,
  input  logic [1:0] dec_op,
  input  logic       dec_shr,
  input  logic       strobe,
  input  logic       done,
  output logic       ir_ce,
  output logic       pc_ce,
  output logic       a_ce,
  output logic       b_ce,
  output logic       c_ce,
  output logic       mar_ce,
  output logic       mdr_ce,
  output logic       mdr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic [1:0] alu_op,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic       shift_right,
  output logic [1:0] c_src,
  output logic       gpr_we,
  output logic [1:0] gpr_dst
);
  always_comb begin
    ir_ce = 1'b0; pc_ce = 1'b0; a_ce = 1'b0; b_ce = 1'b0; c_ce = 1'b0;
    mar_ce = 1'b0; mdr_ce = 1'b0; mdr_sel = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;
    alu_op = OP_ADD; alu_a_sel = 1'b0; alu_b_sel = BS_B; shift_right = 1'b0;
    c_src = CS_ALU; gpr_we = 1'b0; gpr_dst = DS_I;
    case (state)
      S_FETCH:     begin mem_rd = strobe; ir_ce = done; end
      S_DECODE:    begin pc_ce = 1'b1; a_ce = 1'b1; b_ce = 1'b1;
                         alu_a_sel = 1'b1; alu_b_sel = BS_ONE; end
      S_EXE_ALU:   begin c_ce = 1'b1; alu_op = dec_op;
                         alu_b_sel = (cls == C_ALU_I) ? BS_IMM : BS_B; end
      S_EXE_SHIFT: begin c_ce = 1'b1; c_src = CS_SHIFT; shift_right = dec_shr; end
      S_ADDR:      begin mar_ce = 1'b1; alu_b_sel = BS_IMM; end
      S_LD_MEM:    begin mem_rd = strobe; mdr_ce = done; end
      S_LD_COPY:   begin c_ce = 1'b1; c_src = CS_MDR; end
      S_ST_COPY:   begin mdr_ce = 1'b1; mdr_sel = 1'b1; end
      S_ST_MEM:    mem_wr = strobe;
      S_BR_CHK:    begin alu_op = OP_TEQ; alu_b_sel = BS_ZERO; end
      S_BR_TAKEN:  begin pc_ce = 1'b1; alu_a_sel = 1'b1; alu_b_sel = BS_IMM; end
      S_JR,
      S_JL_JUMP:   begin pc_ce = 1'b1; alu_b_sel = BS_ZERO; end
      S_JL_SAVE:   begin c_ce = 1'b1; c_src = CS_PC; end
      S_JL_WB:     begin gpr_we = 1'b1; gpr_dst = DS_LINK; end
      S_WB_I:      begin gpr_we = 1'b1; gpr_dst = DS_I; end
      S_WB_R:      begin gpr_we = 1'b1; gpr_dst = DS_R; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import ctl_pkg::*;
#(
  parameter int IR_W = 32,
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] ir,
  input  logic            mem_busy,
  input  logic            cmp_true,
  output logic            ir_ce,
  output logic            pc_ce,
  output logic            a_ce,
  output logic            b_ce,
  output logic            c_ce,
  output logic            mar_ce,
  output logic            mdr_ce,
  output logic            mdr_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [1:0]      alu_op,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic            shift_right,
  output logic [1:0]      c_src,
  output logic            gpr_we,
  output logic [1:0]      gpr_dst
);
  state_t     state_q, state_d;
  iclass_t    cls;
  logic [1:0] dec_op;
  logic       dec_shr, in_mem, strobe, done, taken;

  ctl_decode #(.IR_W(IR_W), .OP_W(OP_W), .FN_W(FN_W)) u_dec (
    .ir(ir), .cls(cls), .alu_op(dec_op), .shift_right(dec_shr)
  );

  assign in_mem = (state_q == S_FETCH) || (state_q == S_LD_MEM) || (state_q == S_ST_MEM);

  ctl_memwait u_wait (
    .clk(clk), .rst_n(rst_n), .in_mem(in_mem), .busy(mem_busy),
    .strobe(strobe), .done(done)
  );

  assign taken = (cls == C_BEQZ) ? cmp_true : ~cmp_true;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_FETCH:     if (done) state_d = S_DECODE;
      S_DECODE:
        case (cls)
          C_ALU_R, C_ALU_I: state_d = S_EXE_ALU;
          C_SHIFT:          state_d = S_EXE_SHIFT;
          C_LOAD, C_STORE:  state_d = S_ADDR;
          C_BEQZ, C_BNEZ:   state_d = S_BR_CHK;
          C_JR:             state_d = S_JR;
          C_JALR:           state_d = S_JL_SAVE;
          default:          state_d = S_FETCH;
        endcase
      S_EXE_ALU:   state_d = (cls == C_ALU_I) ? S_WB_I : S_WB_R;
      S_EXE_SHIFT: state_d = S_WB_R;
      S_ADDR:      state_d = (cls == C_LOAD) ? S_LD_MEM : S_ST_COPY;
      S_LD_MEM:    if (done) state_d = S_LD_COPY;
      S_LD_COPY:   state_d = S_WB_I;
      S_ST_COPY:   state_d = S_ST_MEM;
      S_ST_MEM:    if (done) state_d = S_FETCH;
      S_BR_CHK:    state_d = taken ? S_BR_TAKEN : S_FETCH;
      S_JL_SAVE:   state_d = S_JL_WB;
      S_JL_WB:     state_d = S_JL_JUMP;
      default:     state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_FETCH;
    else        state_q <= state_d;
  end

  ctl_outputs u_out (
    .state(state_q), .cls(cls), .dec_op(dec_op), .dec_shr(dec_shr),
    .strobe(strobe), .done(done),
    .ir_ce(ir_ce), .pc_ce(pc_ce), .a_ce(a_ce), .b_ce(b_ce), .c_ce(c_ce),
    .mar_ce(mar_ce), .mdr_ce(mdr_ce), .mdr_sel(mdr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_op(alu_op),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .shift_right(shift_right),
    .c_src(c_src), .gpr_we(gpr_we), .gpr_dst(gpr_dst)
  );

  // R4
  decode_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ce |=> (pc_ce && a_ce && b_ce && alu_a_sel));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R12
  link_then_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_we && gpr_dst == DS_LINK) |=> (pc_ce && alu_b_sel == BS_ZERO));

  // R10
  taken_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BR_TAKEN) |-> $past(state_q == S_BR_CHK));
endmodule

// File: tb/tb_mc_sequencer.sv
module tb_mc_sequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mem_busy, cmp_true;
  logic [31:0] ir;
  logic ir_ce, pc_ce, a_ce, b_ce, c_ce, mar_ce, mdr_ce, mdr_sel, mem_rd, mem_wr;
  logic alu_a_sel, shift_right, gpr_we;
  logic [1:0] alu_op, alu_b_sel, c_src, gpr_dst;
  int n_run = 0, n_fail = 0, lat = 0;
  bit finished = 1'b0;

  mc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .mem_busy(mem_busy), .cmp_true(cmp_true),
    .ir_ce(ir_ce), .pc_ce(pc_ce), .a_ce(a_ce), .b_ce(b_ce), .c_ce(c_ce),
    .mar_ce(mar_ce), .mdr_ce(mdr_ce), .mdr_sel(mdr_sel), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .shift_right(shift_right), .c_src(c_src), .gpr_we(gpr_we), .gpr_dst(gpr_dst)
  );

  // memory: busy for lat cycles after each strobe; held busy 3 cycles out of reset
  initial begin
    int pre, rem;
    mem_busy = 1'b1; rem = 0; pre = 3;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (pre > 0) begin mem_busy <= 1'b1; pre--; end
      else if (mem_rd || mem_wr) begin
        if (lat > 0) begin mem_busy <= 1'b1; rem = lat - 1; end
        else begin mem_busy <= 1'b0; rem = 0; end
      end
      else if (rem > 0) begin mem_busy <= 1'b1; rem--; end
      else mem_busy <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(int len, int nwe, int dst, int npc, int pca, int pcb,
      int nrd, int nwr, int nmar, int nmdr, int mdrs, int nc, int csrc, int aop, int bsel, int shr);
    return {15'd0, 8'(len), 4'(nwe), 2'(dst), 4'(npc), 1'(pca), 2'(pcb), 4'(nrd), 4'(nwr),
            4'(nmar), 4'(nmdr), 1'(mdrs), 4'(nc), 2'(csrc), 2'(aop), 2'(bsel), 1'(shr)};
  endfunction

  // R5 encoding table: 0 alu-reg,1 alu-imm,2 shift,3 load,4 store,5 beqz,6 bnez,7 jr,8 jalr,9 undefined
  function automatic int bclass(logic [31:0] i, output int aop, output int shr);
    logic [5:0] op, fn;
    op = i[31:26]; fn = i[5:0]; aop = 0; shr = 0;
    if (op == 6'b000000) begin
      case (fn)
        6'b100011: return 0;
        6'b100010: begin aop = 1; return 0; end
        6'b100100: begin aop = 2; return 0; end
        6'b000000: return 2;
        6'b000010: begin shr = 1; return 2; end
        default:   return 9;
      endcase
    end
    case (op)
      6'b001011: return 1;
      6'b011010: begin aop = 3; return 1; end
      6'b100011: return 3;
      6'b101011: return 4;
      6'b000100: return 5;
      6'b000101: return 6;
      6'b010110: return 7;
      6'b010111: return 8;
      default:   return 9;
    endcase
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0, 1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      5, 6: return "R10";
      7: return "R11";
      8: return "R12";
      default: return "R5";
    endcase
  endfunction

  // called at a negedge where ir_ce is high; runs until the next ir_ce
  task automatic run_one(input logic [31:0] instr, input logic cmp, input int l);
    int len, nwe, dst, npc, pca, pcb, nrd, nwr, nmar, nmdr, mdrs, nc, csrc, aop, bsel, shr;
    int cls, eaop, eshr, f, elen, tk;
    bit dec_ok, tmo;
    logic [63:0] act, exp;
    ir = instr; cmp_true = cmp; lat = l;
    len = 1; nwe = 0; dst = 0; npc = 0; pca = 0; pcb = 0; nrd = 0; nwr = 0; nmar = 0;
    nmdr = 0; mdrs = 0; nc = 0; csrc = 0; aop = 0; bsel = 0; shr = 0; dec_ok = 1'b0; tmo = 1'b0;
    forever begin
      @(negedge clk);
      if (ir_ce) break;
      if (len >= 100) begin tmo = 1'b1; break; end
      if (len == 1)
        dec_ok = pc_ce && a_ce && b_ce && alu_a_sel && alu_b_sel == 2'd3 && alu_op == 2'd0 && !gpr_we;
      if (gpr_we) begin nwe++; dst = gpr_dst; end
      if (pc_ce && len > 1) begin npc++; pca = alu_a_sel; pcb = alu_b_sel; end
      if (mem_rd) nrd++;
      if (mem_wr) nwr++;
      if (mar_ce) nmar++;
      if (mdr_ce) begin nmdr++; mdrs = mdr_sel; end
      if (c_ce) begin
        nc++; csrc = c_src;
        if (c_src == 2'd0) begin aop = alu_op; bsel = alu_b_sel; end
        if (c_src == 2'd1) shr = shift_right;
      end
      len++;
    end
    if (tmo) chk(1'b0, "R2 watchdog: no fetch completion", 64'(len), 64'd0);
    // R4 decode cycle
    chk(dec_ok, $sformatf("R4 decode for %h", instr), {63'd0, dec_ok}, 64'd1);
    cls = bclass(instr, eaop, eshr);
    f = 2 + l;
    elen = f + 1;
    exp = pack(elen, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    case (cls)
      0: exp = pack(elen + 2, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, eaop, 0, 0);
      1: exp = pack(elen + 2, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, eaop, 1, 0);
      2: exp = pack(elen + 2, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1, 0, 0, eshr);
      3: exp = pack(elen + 3 + f, 1, 0, 0, 0, 0, 2, 0, 1, 1, 0, 1, 2, 0, 0, 0);
      4: exp = pack(elen + 2 + f, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
      5, 6: begin
        tk = (cls == 5) ? int'(cmp) : int'(!cmp);
        exp = pack(elen + 1 + tk, 0, 0, tk, tk, tk, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
      7: exp = pack(elen + 1, 0, 0, 1, 0, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      8: exp = pack(elen + 3, 1, 2, 1, 0, 2, 1, 0, 0, 0, 0, 1, 3, 0, 0, 0);
      default: ;
    endcase
    act = pack(len, nwe, dst, npc, pca, pcb, nrd, nwr, nmar, nmdr, mdrs, nc, csrc, aop, bsel, shr);
    chk(act == exp, $sformatf("%s instr=%h cmp=%0d lat=%0d", tag_of(cls), instr, cmp, l), act, exp);
  endtask

  initial begin
    rst_n = 1'b0; ir = 32'd0; cmp_true = 1'b0;
    repeat (3) @(negedge clk);
    // R1 quiet while in reset
    chk(!gpr_we && !pc_ce && !ir_ce && !mem_rd && !mem_wr && !c_ce && !mar_ce && !mdr_ce,
        "R1 reset outputs", {60'd0, gpr_we, pc_ce, ir_ce, mem_rd}, 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      // R3 no request while busy is high
      chk(!mem_rd && !ir_ce, "R3 strobe while busy", {62'd0, mem_rd, ir_ce}, 64'd0);
    end
    @(negedge clk);
    chk(mem_rd, "R2 read strobe once busy low", {63'd0, mem_rd}, 64'd1);
    chk(!gpr_we && !pc_ce && !ir_ce, "R1 no enable before fetch completes",
        {61'd0, gpr_we, pc_ce, ir_ce}, 64'd0);
    @(negedge clk);
    chk(ir_ce && !mem_rd, "R2 ir load after busy low", {62'd0, ir_ce, mem_rd}, 64'd2);
    for (int l = 0; l < 3; l++) begin
      for (int op = 0; op < 64; op++) begin
        if (op == 0) begin
          for (int fn = 0; fn < 64; fn++)
            run_one({6'd0, 5'd3, 5'd4, 5'd5, 5'd0, 6'(fn)}, 1'(fn), l);
        end else if (op == 4 || op == 5) begin
          run_one({6'(op), 5'd7, 5'd9, 16'hFFFC}, 1'b0, l);
          run_one({6'(op), 5'd7, 5'd9, 16'hFFFC}, 1'b1, l);
        end else begin
          run_one({6'(op), 5'd7, 5'd9, 16'h0010}, 1'(op), l);
        end
      end
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL R2 global watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule